// File: doc/BRIEF.md
# Gated Multi-Mode Timer/Counter

A 16-bit timer/counter built from a low byte and a high byte. It increments on every clock cycle (timer) or on each falling edge of an external count pin (counter). A control register sets the run enable, the gate enable, the timer/counter select and one of three counting modes: a 13-bit count (8-bit counter fed by a 5-bit prescaler), a full 16-bit count, and an 8-bit count that reloads itself from the high byte. When the count wraps, a sticky overflow flag is set. An interrupt acknowledge input clears the flag.

Software presets the count through a small byte-wide register port. It then sets the run bit. It can also make counting depend on the level of an external gate pin, which makes the block useful for measuring pulse widths. The formula for the preload is `65536 - ticks` in 16-bit mode. For example, 0xBE77 at 16.777216 MHz gives an overflow every 1 ms, and 0xFFFB in counter mode overflows after five pin edges.

Top module: `tmr16_top`

## Requirements
- R1: After reset the low byte, the high byte and the control register read 0, and `ovf_o` is low.
- R2: Register map, selected by `addr_i`:
  - 0 is the low byte.
  - 1 is the high byte.
  - 2 is control, with bits [1:0] mode, [2] count-pin select, [3] gate enable and [4] run.
  - Control bits [7:5] read 0, and address 3 reads 0.
  - A write takes effect at the clock edge where `wr_en_i` is high.
- R3: Mode 01: each tick increments {high,low} as one 16-bit value. A tick at 0xFFFF gives 0x0000 and sets the overflow flag.
- R4: Mode 00: each tick increments low[4:0]. When low[4:0] wraps from 31 to 0, the high byte increments. A wrap of the high byte from 0xFF sets the overflow flag. low[7:5] keep their value.
- R5: Mode 10: each tick increments the low byte. A tick at 0xFF loads the low byte from the high byte and sets the overflow flag. The high byte is not changed by counting.
- R6: Mode 11: the count holds.
- R7: With run = 0 the count holds.
- R8: With gate = 0, counting ignores `gate_pin_i`. With gate = 1, counting also needs `gate_pin_i` high. The gate pin passes through a two-flop synchroniser, so a change on it takes effect on the third clock edge after the change.
- R9: With the select bit at 0 the block counts clock cycles. With the select bit at 1 it counts only 1-to-0 transitions of `cnt_pin_i` (after a two-flop synchroniser), one tick per transition.
- R10: A write to the low or high byte wins over an increment in the same cycle. That cycle's increment and overflow are dropped.
- R11: `ovf_o` stays set until a cycle with `ovf_ack_i` high clears it. An overflow in the same cycle as the acknowledge leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the addressed register (combinational) |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| gate_pin_i | input | 1 | External gate pin (asynchronous) |
| ovf_ack_i | input | 1 | Interrupt acknowledge, clears the overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The counting function is driven with preloads chosen to separate the modes:
- A mid-range 16-bit value tells a plain increment apart from a wrap.
- 0xFFFE carries through both bytes into overflow.
- Prescaler values of 30 and 31 show the carry into the high byte and keep the upper low bits intact.
- A low byte of 0xFE in reload mode shows the reload value differs from zero.
- The same preload in mode 11 must not move.

The 1 ms preload checks the exact tick count to the overflow. Directed runs then cover:
- edge counting against a steady pin;
- the gate level, including the synchroniser latency;
- a byte write that collides with a tick;
- an acknowledge that collides with an overflow.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MODE_PRESC13 = 2'b00,
    MODE_FULL16  = 2'b01,
    MODE_RELOAD8 = 2'b10,
    MODE_HOLD    = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef struct packed {
    logic      run;
    logic      gate;
    logic      csel;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick
  import tmr16_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tmr_ctrl_t ctrl_i,
  input  logic      cnt_s_i,
  input  logic      gate_s_i,
  output logic      tick_o
);
  logic cnt_prev_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_prev_q <= 1'b0;
    else         cnt_prev_q <= cnt_s_i;
  end

  assign fall = cnt_prev_q & ~cnt_s_i;

  always_comb begin
    tick_o = ctrl_i.run
           & (~ctrl_i.gate | gate_s_i)
           & (ctrl_i.csel ? fall : 1'b1)
           & (ctrl_i.mode != MODE_HOLD);
  end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int W = 8,
  parameter int P = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  tmr_mode_e    mode_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         ovf_evt_o
);
  logic [W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic         evt;

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    evt  = 1'b0;
    // byte writes suppress the increment entirely
    if (tick_i && !(wr_lo_i || wr_hi_i)) begin
      unique case (mode_i)
        MODE_PRESC13: begin
          if (&lo_q[P-1:0]) begin
            lo_n[P-1:0] = '0;
            hi_n        = hi_q + W'(1);
            evt         = &hi_q;
          end else begin
            lo_n[P-1:0] = lo_q[P-1:0] + P'(1);
          end
        end
        MODE_FULL16: begin
          {hi_n, lo_n} = {hi_q, lo_q} + (2*W)'(1);
          evt          = &{hi_q, lo_q};
        end
        MODE_RELOAD8: begin
          if (&lo_q) begin
            lo_n = hi_q;
            evt  = 1'b1;
          end else begin
            lo_n = lo_q + W'(1);
          end
        end
        default: ;
      endcase
    end
    if (wr_lo_i) lo_n = wr_data_i;
    if (wr_hi_i) hi_n = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o      = lo_q;
  assign hi_o      = hi_q;
  assign ovf_evt_o = evt;
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int W         = 8,
  parameter int PRESC_W   = 5,
  parameter int SYNC_STGS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  input  logic         cnt_pin_i,
  input  logic         gate_pin_i,
  input  logic         ovf_ack_i,
  output logic         ovf_o
);
  localparam int PAD_W = W - CTRL_W;

  tmr_ctrl_t    ctrl_q;
  logic         wr_lo, wr_hi, wr_ctrl;
  logic         cnt_s, gate_s, tick, ovf_evt, ovf_q;
  logic [W-1:0] lo, hi;

  assign wr_lo   = wr_en_i && addr_i == ADDR_LO;
  assign wr_hi   = wr_en_i && addr_i == ADDR_HI;
  assign wr_ctrl = wr_en_i && addr_i == ADDR_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  tmr16_sync #(.W(2), .STAGES(SYNC_STGS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({gate_pin_i, cnt_pin_i}),
    .q_o    ({gate_s, cnt_s})
  );

  tmr16_tick u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl_q),
    .cnt_s_i  (cnt_s),
    .gate_s_i (gate_s),
    .tick_o   (tick)
  );

  tmr16_core #(.W(W), .P(PRESC_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (ctrl_q.mode),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .wr_data_i (wr_data_i),
    .lo_o      (lo),
    .hi_o      (hi),
    .ovf_evt_o (ovf_evt)
  );

  // set beats acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_evt)   ovf_q <= 1'b1;
    else if (ovf_ack_i) ovf_q <= 1'b0;
  end

  assign ovf_o = ovf_q;

  always_comb begin
    unique case (addr_i)
      ADDR_LO:   rd_data_o = lo;
      ADDR_HI:   rd_data_o = hi;
      ADDR_CTRL: rd_data_o = {{PAD_W{1'b0}}, ctrl_q};
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int W = 8,
  parameter int P = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ovf_ack_i,
  input logic         ovf_o,
  input logic         ovf_evt,
  input logic         tick,
  input logic [1:0]   mode,
  input logic         run,
  input logic         wr_lo,
  input logic         wr_hi,
  input logic [W-1:0] wr_data_i,
  input logic [W-1:0] lo,
  input logic [W-1:0] hi
);
  p_full_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(tick));

  p_presc_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b00 && !wr_lo) |=> $stable(lo[W-1:P]));

  p_reload_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b10 && !wr_hi) |=> $stable(hi));

  p_hold_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b11 && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

  p_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

  p_wr_priority_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> lo == $past(wr_data_i));

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> ovf_o);

  p_ack_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_ack_i && !ovf_evt) |=> !ovf_o);
endmodule

bind tmr16_top tmr16_chk #(.W(W), .P(PRESC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ovf_ack_i (ovf_ack_i),
  .ovf_o     (ovf_o),
  .ovf_evt   (ovf_evt),
  .tick      (tick),
  .mode      (ctrl_q.mode),
  .run       (ctrl_q.run),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .wr_data_i (wr_data_i),
  .lo        (lo),
  .hi        (hi)
);

// File: tb/sim_tmr16_top.sv
`timescale 1ns/1ps
module sim_tmr16_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [7:0] rd_data_o;
  logic       cnt_pin_i = 1'b1;
  logic       gate_pin_i = 1'b0;
  logic       ovf_ack_i = 1'b0;
  logic       ovf_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  tmr16_top u0 (.*);

  // {mode[3:0], hi, lo, n[15:0], exp_hi, exp_lo, exp_ovf[3:0]}
  localparam int NV = 8;
  localparam logic [55:0] VEC [NV] = '{
    {4'h1, 8'h12, 8'h34, 16'd10,    8'h12, 8'h3E, 4'h0},
    {4'h1, 8'hFF, 8'hFE, 16'd3,     8'h00, 8'h01, 4'h1},
    {4'h0, 8'h05, 8'h1E, 16'd3,     8'h06, 8'h01, 4'h0},
    {4'h0, 8'hFF, 8'hFF, 16'd1,     8'h00, 8'hE0, 4'h1},
    {4'h2, 8'h80, 8'hFE, 16'd4,     8'h80, 8'h82, 4'h1},
    {4'h2, 8'h10, 8'h20, 16'd5,     8'h10, 8'h25, 4'h0},
    {4'h3, 8'h33, 8'h44, 16'd10,    8'h33, 8'h44, 4'h0},
    {4'h1, 8'hBE, 8'h77, 16'd16777, 8'h00, 8'h00, 4'h1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic ack();
    ovf_ack_i = 1'b1;
    @(negedge clk_i);
    ovf_ack_i = 1'b0;
  endtask

  // exactly n ticks in timer mode
  task automatic run_n(input logic [7:0] ctl, input int n);
    wr(2'd2, ctl | 8'h10);
    repeat (n - 1) @(negedge clk_i);
    wr(2'd2, ctl & 8'h0F);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, v); chk("R1 lo", v, 8'h00);
    rd(2'd1, v); chk("R1 hi", v, 8'h00);
    rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 ovf", ovf_o, 0);

    // R2 map
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 ctrl readback", v, 8'h1F);
    rd(2'd3, v); chk("R2 unused addr", v, 8'h00);
    wr(2'd2, 8'h00);

    // vector walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [7:0] md, hv, lv, eh, el;
      int n, eo;
      md = {4'h0, VEC[i][55:52]};
      hv = VEC[i][51:44]; lv = VEC[i][43:36];
      n  = int'(VEC[i][35:20]);
      eh = VEC[i][19:12]; el = VEC[i][11:4];
      eo = int'(VEC[i][3:0]);
      wr(2'd2, md);
      wr(2'd0, lv);
      wr(2'd1, hv);
      ack();
      run_n(md, n);
      rd(2'd0, v); chk($sformatf("R3-R6 vec%0d lo", i), v, el);
      rd(2'd1, v); chk($sformatf("R3-R6 vec%0d hi", i), v, eh);
      chk($sformatf("R3-R6 vec%0d ovf", i), ovf_o, eo);
    end

    // R7 stopped: 20 idle cycles with run clear
    wr(2'd2, 8'h01); wr(2'd0, 8'h40); wr(2'd1, 8'h00);
    repeat (20) @(negedge clk_i);
    rd(2'd0, v); chk("R7 stopped hold", v, 8'h40);

    // R8 gate
    wr(2'd0, 8'h00); ack();
    gate_pin_i = 1'b0;
    wr(2'd2, 8'h19);
    repeat (20) @(negedge clk_i);
    rd(2'd0, v); chk("R8 gated off", v, 8'h00);
    gate_pin_i = 1'b1;
    repeat (10) @(negedge clk_i);
    wr(2'd2, 8'h09);
    rd(2'd0, v); chk("R8 gate latency", v, 8'h09);
    gate_pin_i = 1'b0;
    run_n(8'h01, 6);
    rd(2'd0, v); chk("R8 gate disabled", v, 8'h0F);

    // R9 counter mode: 0xFFFB overflows after five falls
    wr(2'd0, 8'hFB); wr(2'd1, 8'hFF); ack();
    cnt_pin_i = 1'b1;
    wr(2'd2, 8'h15);
    repeat (20) @(negedge clk_i);
    rd(2'd0, v); chk("R9 steady pin", v, 8'hFB);
    for (int k = 0; k < 5; k++) begin
      cnt_pin_i = 1'b0; repeat (4) @(negedge clk_i);
      cnt_pin_i = 1'b1; repeat (4) @(negedge clk_i);
    end
    wr(2'd2, 8'h05);
    rd(2'd0, v); chk("R9 five falls lo", v, 8'h00);
    rd(2'd1, v); chk("R9 five falls hi", v, 8'h00);
    chk("R9 ovf", ovf_o, 1);

    // R10 write beats increment
    ack();
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h11);
    repeat (5) @(negedge clk_i);
    wr(2'd0, 8'h50);
    rd(2'd0, v); chk("R10 write wins", v, 8'h50);
    wr(2'd2, 8'h01);
    rd(2'd0, v); chk("R10 resumes", v, 8'h51);

    // R11 set beats ack, then ack clears
    wr(2'd2, 8'h02); wr(2'd1, 8'h00); wr(2'd0, 8'hFF); ack();
    chk("R11 cleared", ovf_o, 0);
    wr(2'd2, 8'h12);
    ovf_ack_i = 1'b1;
    wr(2'd2, 8'h02);
    ovf_ack_i = 1'b0;
    chk("R11 set wins", ovf_o, 1);
    rd(2'd0, v); chk("R5 reload to zero", v, 8'h00);
    ack();
    chk("R11 ack clears", ovf_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule